// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block sits between a small microcontroller core and a multiplexed external memory bus. The core asks for a program fetch, a data read or a data write by raising a request with a 16-bit address, and with a data byte when it writes. The block then runs one bus cycle, counted in oscillator clocks. It pulses an address latch strobe. It puts the low address byte and then the data on a shared 8-bit port. It drives the high address byte on its own port. It lowers a program-store strobe for a fetch, or an active-low read or write strobe for a data access.

The block reads data back from the shared port at the last clock that its strobe is low. The byte is returned with a one-clock valid pulse. Every strobe edge sits at a fixed clock offset from the start of the cycle, and each offset is a parameter. The block changes all outputs on the clock edge, directly from registers, so external logic never sees a glitch.

Phases are counted from 0, the first clock after the request is accepted. With the default parameters the address latch strobe falls at phase 2. A read or write ends with a tail phase, phase 11, in which the strobe is already high again. A new request can be accepted in that tail, so back-to-back cycles repeat every 12 clocks.

Top module: `ebus_seq`

## Requirements
- R1: While reset is high, and whenever no cycle runs, `ale_o` is 0. `psen_n_o`, `rd_n_o` and `wr_n_o` are 1, and `ad_oe_o`, `busy_o` and `rdata_valid_o` are 0.
- R2: A request is accepted at the clock edge where `busy_o` is low. From the next clock, `ale_o` is high for exactly 2 clocks (phases 0 and 1). The shared port drives the low address byte with its output enable set in phases 0 to 2, which is 1 clock past the fall of `ale_o`.
- R3: A fetch, `kind_i` = 2'b00, drives `psen_n_o` low in phases 3 to 5, which is 3 clocks starting 1 clock after `ale_o` falls. The shared port is released from phase 3 on.
- R4: A fetch samples `ad_i` at the clock edge that ends phase 5. In phase 6 it returns that byte on `rdata_o`, with `rdata_valid_o` high for that single clock.
- R5: A read, `kind_i` = 2'b01, drives `rd_n_o` low in phases 5 to 10. The low address stays driven through phase 4, and the port is released from phase 5. `ad_i` is sampled at the edge that ends phase 10, and `rdata_valid_o` pulses in phase 11 with that byte.
- R6: A write, `kind_i` = 2'b10, drives `wr_n_o` low in phases 5 to 10. The port carries the write byte from phase 3 through phase 11, and its output enable stays high for the whole cycle.
- R7: `ah_o` shows address bits 15:8 from phase 0 and keeps them for the whole cycle, even if `addr_i` changes.
- R8: `busy_o` is high in phases 0 to 5 of a fetch and in phases 0 to 10 of a read or write. A request made while `busy_o` is high has no effect on the cycle in progress.
- R9: A request made in the tail phase 11 of a read or write is accepted, and `ale_o` rises in the next clock. That is 1 clock after the read or write strobe rises.
- R10: A request with `kind_i` = 2'b11 is ignored, and the block stays idle.
- R11: At most one of `psen_n_o`, `rd_n_o` and `wr_n_o` is low at any time. The read and write strobes are never low while `ale_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Request a bus cycle |
| kind_i | input | 2 | 00 fetch, 01 read, 10 write, 11 none |
| addr_i | input | 16 | Cycle address |
| wdata_i | input | 8 | Write byte |
| ad_i | input | 8 | Shared port input side |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_n_o | output | 1 | Program-store strobe, active low |
| rd_n_o | output | 1 | Data read strobe, active low |
| wr_n_o | output | 1 | Data write strobe, active low |
| ad_o | output | 8 | Shared port output side |
| ad_oe_o | output | 1 | Shared port output enable |
| ah_o | output | 8 | High address byte |
| busy_o | output | 1 | Cycle in progress, requests refused |
| rdata_o | output | 8 | Fetched or read byte |
| rdata_valid_o | output | 1 | One-clock pulse marking `rdata_o` |

## Verification
Each request is driven half a clock before the edge that accepts it. Phase k of the cycle is therefore observed at the falling edge k+1 clocks later, and every output is compared there against a phase table worked out from the requirements. The input byte is placed on `ad_i` only during the one phase whose closing edge should sample it, with its complement in every other phase. As a result, the returned byte is right only if the capture happens at that edge and no other. The valid pulse is expected one phase after the sampling phase, in phase 6 for a fetch and phase 11 for a read. Back-to-back cycles are started from the tail phase, so `ale_o` must rise exactly in the next observed clock.

// File: rtl/ebus_pkg.sv
package ebus_pkg;

  typedef enum logic [1:0] {
    XK_FETCH = 2'b00,
    XK_READ  = 2'b01,
    XK_WRITE = 2'b10,
    XK_NONE  = 2'b11
  } xfer_kind_e;

endpackage

// File: rtl/ebus_phase_ctr.sv
module ebus_phase_ctr
  import ebus_pkg::*;
#(
  parameter int PH_W      = 4,
  parameter int FETCH_END = 5,
  parameter int RW_END    = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_i,
  input  xfer_kind_e      kind_i,
  output logic            accept_o,
  output logic            act_o,
  output xfer_kind_e      kind_o,
  output logic [PH_W-1:0] ph_o,
  output logic            act_nxt_o,
  output xfer_kind_e      kind_nxt_o,
  output logic [PH_W-1:0] ph_nxt_o,
  output logic            busy_nxt_o
);

  localparam logic [PH_W-1:0] L_F_END  = PH_W'(FETCH_END);
  localparam logic [PH_W-1:0] L_RW_END = PH_W'(RW_END);

  logic            act_q;
  xfer_kind_e      kind_q;
  logic [PH_W-1:0] ph_q;

  logic            act_n;
  xfer_kind_e      kind_n;
  logic [PH_W-1:0] ph_n;
  logic            busy_cur;
  logic            accept;
  logic            at_end;

  // the tail phase of a data cycle counts as free
  assign busy_cur = act_q && !(kind_q != XK_FETCH && ph_q == L_RW_END);
  assign at_end   = (kind_q == XK_FETCH) ? (ph_q == L_F_END) : (ph_q == L_RW_END);

  always_comb begin
    accept = req_i && (kind_i != XK_NONE) && !busy_cur;
    act_n  = act_q;
    kind_n = kind_q;
    ph_n   = ph_q;
    if (accept) begin
      act_n  = 1'b1;
      kind_n = kind_i;
      ph_n   = '0;
    end else if (act_q) begin
      if (at_end) begin
        act_n = 1'b0;
        ph_n  = '0;
      end else begin
        ph_n = ph_q + PH_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b0;
      kind_q <= XK_FETCH;
      ph_q   <= '0;
    end else begin
      act_q  <= act_n;
      kind_q <= kind_n;
      ph_q   <= ph_n;
    end
  end

  assign accept_o   = accept;
  assign act_o      = act_q;
  assign kind_o     = kind_q;
  assign ph_o       = ph_q;
  assign act_nxt_o  = act_n;
  assign kind_nxt_o = kind_n;
  assign ph_nxt_o   = ph_n;
  assign busy_nxt_o = act_n && !(kind_n != XK_FETCH && ph_n == L_RW_END);

endmodule

// File: rtl/ebus_strobe_gen.sv
module ebus_strobe_gen
  import ebus_pkg::*;
#(
  parameter int PH_W     = 4,
  parameter int ALE_W    = 2,
  parameter int PSEN_ON  = 3,
  parameter int PSEN_OFF = 6,
  parameter int RW_ON    = 5,
  parameter int RW_OFF   = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            act_nxt_i,
  input  xfer_kind_e      kind_nxt_i,
  input  logic [PH_W-1:0] ph_nxt_i,
  input  logic            busy_nxt_i,
  output logic            ale_o,
  output logic            psen_n_o,
  output logic [1:0]      rw_n_o,
  output logic            busy_o
);

  localparam logic [PH_W-1:0] L_ALE_END = PH_W'(ALE_W);
  localparam logic [PH_W-1:0] L_PS_ON   = PH_W'(PSEN_ON);
  localparam logic [PH_W-1:0] L_PS_OFF  = PH_W'(PSEN_OFF);
  localparam logic [PH_W-1:0] L_RW_ON   = PH_W'(RW_ON);
  localparam logic [PH_W-1:0] L_RW_OFF  = PH_W'(RW_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      ale_o    <= 1'b0;
      psen_n_o <= 1'b1;
      busy_o   <= 1'b0;
    end else begin
      ale_o    <= act_nxt_i && (ph_nxt_i < L_ALE_END);
      psen_n_o <= !(act_nxt_i && kind_nxt_i == XK_FETCH &&
                    ph_nxt_i >= L_PS_ON && ph_nxt_i < L_PS_OFF);
      busy_o   <= busy_nxt_i;
    end
  end

  // one identical low-going strobe per data direction: 0 read, 1 write
  for (genvar g = 0; g < 2; g++) begin : g_rw
    localparam xfer_kind_e K = (g == 0) ? XK_READ : XK_WRITE;
    logic strobe_n_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        strobe_n_q <= 1'b1;
      end else begin
        strobe_n_q <= !(act_nxt_i && kind_nxt_i == K &&
                        ph_nxt_i >= L_RW_ON && ph_nxt_i < L_RW_OFF);
      end
    end
    assign rw_n_o[g] = strobe_n_q;
  end

endmodule

// File: rtl/ebus_ad_mux.sv
module ebus_ad_mux
  import ebus_pkg::*;
#(
  parameter int PH_W     = 4,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int ALE_W    = 2,
  parameter int PSEN_OFF = 6,
  parameter int RW_ON    = 5,
  parameter int RW_OFF   = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               accept_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [DATA_W-1:0]  ad_i,
  input  logic               act_i,
  input  xfer_kind_e         kind_i,
  input  logic [PH_W-1:0]    ph_i,
  input  logic               act_nxt_i,
  input  xfer_kind_e         kind_nxt_i,
  input  logic [PH_W-1:0]    ph_nxt_i,
  output logic [DATA_W-1:0]  ad_o,
  output logic               ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] ah_o,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rdata_valid_o
);

  localparam int HI_W = ADDR_W - DATA_W;
  localparam logic [PH_W-1:0] L_AHOLD  = PH_W'(ALE_W);
  localparam logic [PH_W-1:0] L_RW_ON  = PH_W'(RW_ON);
  localparam logic [PH_W-1:0] L_F_SAMP = PH_W'(PSEN_OFF - 1);
  localparam logic [PH_W-1:0] L_R_SAMP = PH_W'(RW_OFF - 1);

  logic [DATA_W-1:0] lo_q, lo_n;
  logic [DATA_W-1:0] wd_q, wd_n;
  logic [HI_W-1:0]   hi_n;
  logic              addr_ph, data_ph, capture;

  assign lo_n = accept_i ? addr_i[DATA_W-1:0] : lo_q;
  assign wd_n = accept_i ? wdata_i : wd_q;
  assign hi_n = accept_i ? addr_i[ADDR_W-1:DATA_W] : ah_o;

  // a read keeps the address on the port until its strobe falls
  assign addr_ph = act_nxt_i && ((ph_nxt_i <= L_AHOLD) ||
                   (kind_nxt_i == XK_READ && ph_nxt_i < L_RW_ON));
  assign data_ph = act_nxt_i && kind_nxt_i == XK_WRITE && ph_nxt_i > L_AHOLD;

  assign capture = act_i && ((kind_i == XK_FETCH && ph_i == L_F_SAMP) ||
                             (kind_i == XK_READ  && ph_i == L_R_SAMP));

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q          <= '0;
      wd_q          <= '0;
      ah_o          <= '0;
      ad_o          <= '0;
      ad_oe_o       <= 1'b0;
      rdata_o       <= '0;
      rdata_valid_o <= 1'b0;
    end else begin
      lo_q    <= lo_n;
      wd_q    <= wd_n;
      ah_o    <= hi_n;
      ad_oe_o <= addr_ph || data_ph;
      if (addr_ph) begin
        ad_o <= lo_n;
      end else if (data_ph) begin
        ad_o <= wd_n;
      end else begin
        ad_o <= '0;
      end
      rdata_valid_o <= capture;
      if (capture) begin
        rdata_o <= ad_i;
      end
    end
  end

endmodule

// File: rtl/ebus_seq.sv
module ebus_seq
  import ebus_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int ALE_W    = 2,
  parameter int PSEN_DLY = 1,
  parameter int PSEN_W   = 3,
  parameter int RW_DLY   = 3,
  parameter int RW_W     = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req_i,
  input  logic [1:0]               kind_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [DATA_W-1:0]        wdata_i,
  input  logic [DATA_W-1:0]        ad_i,
  output logic                     ale_o,
  output logic                     psen_n_o,
  output logic                     rd_n_o,
  output logic                     wr_n_o,
  output logic [DATA_W-1:0]        ad_o,
  output logic                     ad_oe_o,
  output logic [ADDR_W-DATA_W-1:0] ah_o,
  output logic                     busy_o,
  output logic [DATA_W-1:0]        rdata_o,
  output logic                     rdata_valid_o
);

  localparam int PSEN_ON  = ALE_W + PSEN_DLY;
  localparam int PSEN_OFF = PSEN_ON + PSEN_W;
  localparam int RW_ON    = ALE_W + RW_DLY;
  localparam int RW_OFF   = RW_ON + RW_W;
  localparam int PH_W     = $clog2(RW_OFF + 1);

  logic            accept;
  logic            act;
  xfer_kind_e      kind;
  logic [PH_W-1:0] ph;
  logic            act_nxt;
  xfer_kind_e      kind_nxt;
  logic [PH_W-1:0] ph_nxt;
  logic            busy_nxt;
  logic [1:0]      rw_n;

  ebus_phase_ctr #(
    .PH_W      (PH_W),
    .FETCH_END (PSEN_OFF - 1),
    .RW_END    (RW_OFF)
  ) i_ctr (
    .clk        (clk),
    .rst        (rst),
    .req_i      (req_i),
    .kind_i     (xfer_kind_e'(kind_i)),
    .accept_o   (accept),
    .act_o      (act),
    .kind_o     (kind),
    .ph_o       (ph),
    .act_nxt_o  (act_nxt),
    .kind_nxt_o (kind_nxt),
    .ph_nxt_o   (ph_nxt),
    .busy_nxt_o (busy_nxt)
  );

  ebus_strobe_gen #(
    .PH_W     (PH_W),
    .ALE_W    (ALE_W),
    .PSEN_ON  (PSEN_ON),
    .PSEN_OFF (PSEN_OFF),
    .RW_ON    (RW_ON),
    .RW_OFF   (RW_OFF)
  ) i_strobe (
    .clk        (clk),
    .rst        (rst),
    .act_nxt_i  (act_nxt),
    .kind_nxt_i (kind_nxt),
    .ph_nxt_i   (ph_nxt),
    .busy_nxt_i (busy_nxt),
    .ale_o      (ale_o),
    .psen_n_o   (psen_n_o),
    .rw_n_o     (rw_n),
    .busy_o     (busy_o)
  );

  ebus_ad_mux #(
    .PH_W     (PH_W),
    .DATA_W   (DATA_W),
    .ADDR_W   (ADDR_W),
    .ALE_W    (ALE_W),
    .PSEN_OFF (PSEN_OFF),
    .RW_ON    (RW_ON),
    .RW_OFF   (RW_OFF)
  ) i_ad (
    .clk           (clk),
    .rst           (rst),
    .accept_i      (accept),
    .addr_i        (addr_i),
    .wdata_i       (wdata_i),
    .ad_i          (ad_i),
    .act_i         (act),
    .kind_i        (kind),
    .ph_i          (ph),
    .act_nxt_i     (act_nxt),
    .kind_nxt_i    (kind_nxt),
    .ph_nxt_i      (ph_nxt),
    .ad_o          (ad_o),
    .ad_oe_o       (ad_oe_o),
    .ah_o          (ah_o),
    .rdata_o       (rdata_o),
    .rdata_valid_o (rdata_valid_o)
  );

  assign rd_n_o = rw_n[0];
  assign wr_n_o = rw_n[1];

endmodule

// File: rtl/ebus_seq_chk.sv
module ebus_seq_chk #(
  parameter int HI_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            ale_o,
  input logic            psen_n_o,
  input logic            rd_n_o,
  input logic            wr_n_o,
  input logic            ad_oe_o,
  input logic [HI_W-1:0] ah_o,
  input logic            busy_o
);

  // R2: the latch strobe is high for exactly two clocks
  a_r2_ale_min: assert property (@(posedge clk) disable iff (rst)
    $fell(ale_o) |-> $past(ale_o, 2));
  a_r2_ale_max: assert property (@(posedge clk) disable iff (rst)
    (ale_o && $past(ale_o)) |=> !ale_o);

  // R3: program-store strobe falls one clock after the latch strobe falls
  a_r3_psen_offset: assert property (@(posedge clk) disable iff (rst)
    $fell(psen_n_o) |-> (!$past(ale_o) && $past(ale_o, 2)));

  // R5 and R6: data strobes fall three clocks after the latch strobe falls
  a_r5_rw_offset: assert property (@(posedge clk) disable iff (rst)
    ($fell(rd_n_o) || $fell(wr_n_o)) |-> (!$past(ale_o, 3) && $past(ale_o, 4)));

  // R5: port released while reading
  a_r5_read_released: assert property (@(posedge clk) disable iff (rst)
    !rd_n_o |-> !ad_oe_o);

  // R6: port driven while writing
  a_r6_write_driven: assert property (@(posedge clk) disable iff (rst)
    !wr_n_o |-> ad_oe_o);

  // R7: high address steady within a cycle
  a_r7_ah_stable: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(ah_o));

  // R8: no new cycle starts while busy
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> !$rose(ale_o));

  // R11: strobes exclusive, data strobes apart from the latch strobe
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!psen_n_o, !rd_n_o, !wr_n_o}));
  a_r11_rw_not_ale: assert property (@(posedge clk) disable iff (rst)
    (!rd_n_o || !wr_n_o) |-> !ale_o);

endmodule

bind ebus_seq ebus_seq_chk #(.HI_W(ADDR_W - DATA_W)) i_chk (
  .clk      (clk),
  .rst      (rst),
  .ale_o    (ale_o),
  .psen_n_o (psen_n_o),
  .rd_n_o   (rd_n_o),
  .wr_n_o   (wr_n_o),
  .ad_oe_o  (ad_oe_o),
  .ah_o     (ah_o),
  .busy_o   (busy_o)
);

// File: tb/test_ebus_seq.sv
module test_ebus_seq;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_i;
  logic [1:0]  kind_i;
  logic [15:0] addr_i;
  logic [7:0]  wdata_i;
  logic [7:0]  ad_i;
  logic        ale_o, psen_n_o, rd_n_o, wr_n_o, ad_oe_o, busy_o, rdata_valid_o;
  logic [7:0]  ad_o, ah_o, rdata_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  ebus_seq i_ebus_seq (
    .clk (clk), .rst (rst), .req_i (req_i), .kind_i (kind_i),
    .addr_i (addr_i), .wdata_i (wdata_i), .ad_i (ad_i),
    .ale_o (ale_o), .psen_n_o (psen_n_o), .rd_n_o (rd_n_o), .wr_n_o (wr_n_o),
    .ad_o (ad_o), .ad_oe_o (ad_oe_o), .ah_o (ah_o), .busy_o (busy_o),
    .rdata_o (rdata_o), .rdata_valid_o (rdata_valid_o)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // expected phase table, kind 0 fetch, 1 read, 2 write
  function automatic logic e_ale(int ph);
    return ph < 2;
  endfunction
  function automatic logic e_psen_n(logic [1:0] k, int ph);
    return !(k == 2'd0 && ph >= 3 && ph <= 5);
  endfunction
  function automatic logic e_rd_n(logic [1:0] k, int ph);
    return !(k == 2'd1 && ph >= 5 && ph <= 10);
  endfunction
  function automatic logic e_wr_n(logic [1:0] k, int ph);
    return !(k == 2'd2 && ph >= 5 && ph <= 10);
  endfunction
  function automatic logic e_addr_ph(logic [1:0] k, int ph);
    return (ph <= 2) || (k == 2'd1 && ph < 5);
  endfunction
  function automatic logic e_oe(logic [1:0] k, int ph);
    return (k == 2'd2) ? (ph <= 11) : e_addr_ph(k, ph);
  endfunction
  function automatic logic e_busy(logic [1:0] k, int ph);
    return (k == 2'd0) ? (ph <= 5) : (ph <= 10);
  endfunction
  function automatic logic e_valid(logic [1:0] k, int ph);
    return (k == 2'd0 && ph == 6) || (k == 2'd1 && ph == 11);
  endfunction
  function automatic int samp_ph(logic [1:0] k);
    return (k == 2'd0) ? 5 : ((k == 2'd1) ? 10 : -1);
  endfunction
  function automatic string ktag(logic [1:0] k);
    return (k == 2'd0) ? "R3" : ((k == 2'd1) ? "R5" : "R6");
  endfunction

  task automatic chk_idle(string tag);
    chk({tag, " ale"}, 16'(ale_o), 16'd0);
    chk({tag, " psen_n"}, 16'(psen_n_o), 16'd1);
    chk({tag, " rd_n"}, 16'(rd_n_o), 16'd1);
    chk({tag, " wr_n"}, 16'(wr_n_o), 16'd1);
    chk({tag, " oe"}, 16'(ad_oe_o), 16'd0);
    chk({tag, " busy"}, 16'(busy_o), 16'd0);
    chk({tag, " valid"}, 16'(rdata_valid_o), 16'd0);
  endtask

  // caller is at a falling edge with the block free to accept
  task automatic run_cycle(logic [1:0] k, logic [15:0] a, logic [7:0] wd,
                           logic [7:0] din, bit intrude);
    int last;
    last    = (k == 2'd0) ? 6 : 11;
    req_i   = 1'b1;
    kind_i  = k;
    addr_i  = a;
    wdata_i = wd;
    ad_i    = ~din;
    for (int ph = 0; ph <= last; ph++) begin
      @(negedge clk);
      if (ph == 0) begin
        req_i   = 1'b0;
        addr_i  = 16'($urandom);
        wdata_i = 8'($urandom);
      end
      chk("R2 ale", 16'(ale_o), 16'(e_ale(ph)));
      chk("R3 psen_n", 16'(psen_n_o), 16'(e_psen_n(k, ph)));
      chk("R5 rd_n", 16'(rd_n_o), 16'(e_rd_n(k, ph)));
      chk("R6 wr_n", 16'(wr_n_o), 16'(e_wr_n(k, ph)));
      chk({ktag(k), " oe"}, 16'(ad_oe_o), 16'(e_oe(k, ph)));
      if (e_oe(k, ph)) begin
        if (e_addr_ph(k, ph)) chk("R2 ad address", 16'(ad_o), 16'(a[7:0]));
        else                  chk("R6 ad data", 16'(ad_o), 16'(wd));
      end
      chk("R7 ah", 16'(ah_o), 16'(a[15:8]));
      chk("R8 busy", 16'(busy_o), 16'(e_busy(k, ph)));
      chk((k == 2'd0) ? "R4 valid" : "R5 valid", 16'(rdata_valid_o), 16'(e_valid(k, ph)));
      if (e_valid(k, ph))
        chk((k == 2'd0) ? "R4 rdata" : "R5 rdata", 16'(rdata_o), 16'(din));
      chk("R11 strobes", 16'($countones({~psen_n_o, ~rd_n_o, ~wr_n_o}) <= 1), 16'd1);
      // R8: a request during a busy phase must be ignored
      if (intrude && ph == 2) begin
        req_i  = 1'b1;
        kind_i = 2'($urandom);
      end
      if (ph == 3) req_i = 1'b0;
      ad_i = (ph == samp_ph(k)) ? din : ~din;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; req_i = 1'b0; kind_i = 2'd0;
    addr_i = '0; wdata_i = '0; ad_i = '0;
    repeat (3) @(negedge clk);
    chk_idle("R1 reset");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 after reset");

    // directed cycles
    run_cycle(2'd0, 16'h12A5, 8'h00, 8'h3C, 1'b0);
    @(negedge clk); chk_idle("R1 after fetch");
    run_cycle(2'd1, 16'hFE01, 8'h00, 8'hC3, 1'b1);
    @(negedge clk); chk_idle("R1 after read");
    run_cycle(2'd2, 16'h80FF, 8'h5A, 8'h00, 1'b1);
    @(negedge clk); chk_idle("R1 after write");

    // R9: back-to-back from the tail phase
    run_cycle(2'd1, 16'h0102, 8'h00, 8'h81, 1'b0);
    run_cycle(2'd2, 16'h0304, 8'hA7, 8'h00, 1'b0);
    run_cycle(2'd0, 16'h0506, 8'h00, 8'h7E, 1'b0);
    @(negedge clk); chk_idle("R9 chain end");

    // R10: kind 11 requests are ignored
    req_i = 1'b1; kind_i = 2'b11; addr_i = 16'hBEEF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_idle("R10 none kind");
    end
    req_i = 1'b0;

    // random mix
    for (int i = 0; i < 40; i++) begin
      int gap;
      gap = ($urandom % 2 == 0) ? 0 : 1 + int'($urandom % 3);
      for (int j = 0; j < gap; j++) begin
        @(negedge clk);
        chk_idle("R1 random idle");
      end
      run_cycle(2'($urandom % 3), 16'($urandom), 8'($urandom), 8'($urandom),
                1'($urandom));
    end
    @(negedge clk); chk_idle("R1 final");
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

endmodule